// File: doc/BRIEF.md
# Decimal Adjust Unit

This block repairs the byte-level result of an ordinary binary add, subtract, multiply or divide so that it becomes valid decimal data, either two digits per byte (packed) or one digit per byte held in the low nibble (unpacked). It takes a 16-bit accumulator split into a high and a low byte, the incoming auxiliary-carry and carry flags, a 3-bit operation code, an 8-bit immediate and a legacy-mode select. It returns the corrected accumulator, the new flags and a divide-error indication.

The correction logic is purely combinational. Its result is captured in one register stage, so a value presented before a rising clock edge appears at the outputs just after that edge. The block does not check whether the operands are proper decimal digits. Non-decimal inputs produce the exact arithmetic the rules below define.

Top module: `decadj_unit`

## Requirements
- R1: While the active-low reset is asserted, all outputs are zero: both accumulator bytes, both flags and the divide-error flag.
- R2: Each result is registered once and appears after the first rising edge following the inputs. The operation codes are 0 unpacked-add adjust, 1 unpacked-subtract adjust, 2 packed-add adjust, 3 packed-subtract adjust, 4 multiply adjust and 5 divide adjust. Codes 6 and 7 return the accumulator and both flags unchanged, with divide-error low.
- R3: In unpacked-add adjust in normal mode, a low-nibble value above 9 or a set auxiliary carry is the adjust condition. When it holds, 6 is added to the whole 16-bit accumulator, then the high byte is incremented once more, and both flags are set.
- R4: In unpacked-add adjust in legacy mode, the +6 is applied to the low byte alone, with no ripple into the high byte. The high byte still gains exactly one.
- R5: In both unpacked adjusts, when the condition is false both flags are cleared and the high byte is kept. Whatever the condition, the upper nibble of the low byte is forced to zero.
- R6: In unpacked-subtract adjust, when the condition of R3 holds, 6 is subtracted from the low byte and the high byte is decremented, and both flags are set.
- R7: In packed-add adjust, the low-nibble condition of R3 adds 6 and makes the auxiliary-carry output 1; otherwise that output is 0. A low byte above 9Fh or a set carry then adds 60h and makes the carry output 1; otherwise that output is 0. The high byte is unchanged.
- R8: Packed-subtract adjust uses the same two conditions and flag results as R7, but subtracts 6 and 60h instead.
- R9: In both packed adjusts, the comparison with 9Fh uses the low byte as it arrived, before the +6 or -6 step.
- R10: In multiply adjust with a nonzero immediate, the high byte becomes the low input byte divided by the immediate and the low byte becomes the remainder. Both flags pass through.
- R11: In multiply adjust with a zero immediate, divide-error goes high and the accumulator and flags are returned unchanged. Divide-error is low for every other operation.
- R12: In divide adjust, the low byte becomes (high byte × BASE + low byte) modulo 256, the high byte becomes zero and both flags pass through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_hi_i | input | 8 | High byte of the accumulator |
| acc_lo_i | input | 8 | Low byte of the accumulator |
| aux_i | input | 1 | Incoming auxiliary (nibble) carry flag |
| carry_i | input | 1 | Incoming carry flag |
| op_i | input | 3 | Operation code, encoding per R2 |
| imm_i | input | 8 | Divisor used by multiply adjust |
| legacy_i | input | 1 | Selects byte-only correction in unpacked-add adjust |
| acc_hi_o | output | 8 | Corrected high byte |
| acc_lo_o | output | 8 | Corrected low byte |
| aux_o | output | 1 | New auxiliary carry flag |
| carry_o | output | 1 | New carry flag |
| div_err_o | output | 1 | Zero divisor in multiply adjust |

## Verification
The bench builds the unit with its defaults: an 8-bit byte width and a divide-adjust scale of 10. At that size every one of the 256 low-byte values can be swept under each of the eight operation codes. The sweep reaches the 9Fh threshold, the nibble boundary at 9/Ah, the wrap in both directions and a zero immediate. Directed vectors with hand-worked results separate the normal and legacy unpacked-add paths and cover the carry-in-only packed cases.

// File: rtl/decadj_pkg.sv
package decadj_pkg;

    typedef enum logic [2:0] {
        OP_UADD   = 3'd0,
        OP_USUB   = 3'd1,
        OP_PADD   = 3'd2,
        OP_PSUB   = 3'd3,
        OP_MULADJ = 3'd4,
        OP_DIVADJ = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } decadj_op_e;

    localparam int unsigned DIGIT_LIMIT = 9;

endpackage

// File: rtl/decadj_unpacked.sv
module decadj_unpacked #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] hi_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic              aux_i,
    input  logic              subtract_i,
    input  logic              legacy_i,
    output logic [BYTE_W-1:0] hi_o,
    output logic [BYTE_W-1:0] lo_o,
    output logic              flag_o
);
    import decadj_pkg::*;

    localparam int unsigned   WORD_W = 2 * BYTE_W;
    localparam logic [BYTE_W-1:0] SIX_B  = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] ONE_B  = BYTE_W'(1);
    localparam logic [BYTE_W-1:0] NIB_MASK = BYTE_W'(15);
    localparam logic [WORD_W-1:0] SIX_W  = WORD_W'(6);

    logic              fix;
    logic [WORD_W-1:0] word_sum;
    logic [BYTE_W-1:0] hi_t, lo_t;

    assign fix      = (lo_i[3:0] > 4'(DIGIT_LIMIT)) || aux_i;
    assign word_sum = {hi_i, lo_i} + SIX_W;

    always_comb begin
        hi_t = hi_i;
        lo_t = lo_i;
        if (fix) begin
            if (subtract_i) begin
                lo_t = lo_i - SIX_B;
                hi_t = hi_i - ONE_B;
            end else if (legacy_i) begin
                lo_t = lo_i + SIX_B;
                hi_t = hi_i + ONE_B;
            end else begin
                lo_t = word_sum[BYTE_W-1:0];
                hi_t = word_sum[WORD_W-1:BYTE_W] + ONE_B;
            end
        end
    end

    assign hi_o   = hi_t;
    assign lo_o   = lo_t & NIB_MASK;
    assign flag_o = fix;

endmodule

// File: rtl/decadj_packed.sv
module decadj_packed #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] lo_i,
    input  logic              aux_i,
    input  logic              carry_i,
    input  logic              subtract_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic              aux_o,
    output logic              carry_o
);
    import decadj_pkg::*;

    localparam logic [BYTE_W-1:0] LOW_STEP  = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] HIGH_STEP = BYTE_W'(96);
    localparam logic [BYTE_W-1:0] HIGH_LIM  = BYTE_W'(159);

    logic              low_fix, high_fix;
    logic [BYTE_W-1:0] step;

    assign low_fix  = (lo_i[3:0] > 4'(DIGIT_LIMIT)) || aux_i;
    assign high_fix = (lo_i > HIGH_LIM) || carry_i;

    always_comb begin
        step = '0;
        if (low_fix)  step = step + LOW_STEP;
        if (high_fix) step = step + HIGH_STEP;
    end

    assign lo_o    = subtract_i ? (lo_i - step) : (lo_i + step);
    assign aux_o   = low_fix;
    assign carry_o = high_fix;

endmodule

// File: rtl/decadj_muldiv.sv
module decadj_muldiv #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned BASE   = 10
) (
    input  logic [BYTE_W-1:0] hi_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] imm_i,
    input  logic              div_sel_i,
    output logic [BYTE_W-1:0] hi_o,
    output logic [BYTE_W-1:0] lo_o,
    output logic              err_o
);
    localparam logic [BYTE_W-1:0] BASE_B = BYTE_W'(BASE);

    logic zero_div;

    assign zero_div = (imm_i == '0);

    always_comb begin
        hi_o  = hi_i;
        lo_o  = lo_i;
        err_o = 1'b0;
        if (div_sel_i) begin
            hi_o = '0;
            lo_o = hi_i * BASE_B + lo_i;
        end else if (zero_div) begin
            err_o = 1'b1;
        end else begin
            hi_o = lo_i / imm_i;
            lo_o = lo_i % imm_i;
        end
    end

endmodule

// File: rtl/decadj_unit.sv
module decadj_unit #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned BASE   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] acc_hi_i,
    input  logic [BYTE_W-1:0] acc_lo_i,
    input  logic              aux_i,
    input  logic              carry_i,
    input  logic [2:0]        op_i,
    input  logic [BYTE_W-1:0] imm_i,
    input  logic              legacy_i,
    output logic [BYTE_W-1:0] acc_hi_o,
    output logic [BYTE_W-1:0] acc_lo_o,
    output logic              aux_o,
    output logic              carry_o,
    output logic              div_err_o
);
    import decadj_pkg::*;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic              aux;
        logic              carry;
        logic              err;
    } adj_res_t;

    decadj_op_e op;
    adj_res_t   res_d, res_q;

    logic [BYTE_W-1:0] up_hi, up_lo, pk_lo, md_hi, md_lo;
    logic              up_flag, pk_aux, pk_carry, md_err;

    assign op = decadj_op_e'(op_i);

    decadj_unpacked #(.BYTE_W(BYTE_W)) u_unpacked (
        .hi_i       (acc_hi_i),
        .lo_i       (acc_lo_i),
        .aux_i      (aux_i),
        .subtract_i (op == OP_USUB),
        .legacy_i   (legacy_i),
        .hi_o       (up_hi),
        .lo_o       (up_lo),
        .flag_o     (up_flag)
    );

    decadj_packed #(.BYTE_W(BYTE_W)) u_packed (
        .lo_i       (acc_lo_i),
        .aux_i      (aux_i),
        .carry_i    (carry_i),
        .subtract_i (op == OP_PSUB),
        .lo_o       (pk_lo),
        .aux_o      (pk_aux),
        .carry_o    (pk_carry)
    );

    decadj_muldiv #(.BYTE_W(BYTE_W), .BASE(BASE)) u_muldiv (
        .hi_i      (acc_hi_i),
        .lo_i      (acc_lo_i),
        .imm_i     (imm_i),
        .div_sel_i (op == OP_DIVADJ),
        .hi_o      (md_hi),
        .lo_o      (md_lo),
        .err_o     (md_err)
    );

    always_comb begin
        res_d = '{hi: acc_hi_i, lo: acc_lo_i, aux: aux_i, carry: carry_i, err: 1'b0};
        case (op)
            OP_UADD, OP_USUB: begin
                res_d.hi    = up_hi;
                res_d.lo    = up_lo;
                res_d.aux   = up_flag;
                res_d.carry = up_flag;
            end
            OP_PADD, OP_PSUB: begin
                res_d.lo    = pk_lo;
                res_d.aux   = pk_aux;
                res_d.carry = pk_carry;
            end
            OP_MULADJ, OP_DIVADJ: begin
                res_d.hi  = md_hi;
                res_d.lo  = md_lo;
                res_d.err = md_err;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign acc_hi_o  = res_q.hi;
    assign acc_lo_o  = res_q.lo;
    assign aux_o     = res_q.aux;
    assign carry_o   = res_q.carry;
    assign div_err_o = res_q.err;

    // R5
    unpacked_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 || op_i == 3'd1) |=> (acc_lo_o[BYTE_W-1:4] == '0 && aux_o == carry_o));

    // R7
    packed_carry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 3'd2 || op_i == 3'd3) && carry_i) |=> (carry_o && acc_hi_o == $past(acc_hi_i)));

    // R11
    zero_imm_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4 && imm_i == '0) |=> (div_err_o && acc_lo_o == $past(acc_lo_i)
                                           && acc_hi_o == $past(acc_hi_i)));

    // R11
    err_only_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 3'd4) |=> !div_err_o);

    // R10
    remainder_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4 && imm_i != '0) |=> (acc_lo_o < $past(imm_i) && aux_o == $past(aux_i)));

    // R12
    div_hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5) |=> (acc_hi_o == '0 && carry_o == $past(carry_i)));

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2:1] == 2'b11) |=> ($stable(acc_hi_o) || acc_hi_o == $past(acc_hi_i)));

endmodule

// File: tb/tb_decadj_unit.sv
module tb_decadj_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_hi_i = '0, acc_lo_i = '0, imm_i = 8'd10;
    logic       aux_i = 1'b0, carry_i = 1'b0, legacy_i = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [7:0] acc_hi_o, acc_lo_o;
    logic       aux_o, carry_o, div_err_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    decadj_unit dut (
        .clk(clk), .rst_n(rst_n),
        .acc_hi_i(acc_hi_i), .acc_lo_i(acc_lo_i),
        .aux_i(aux_i), .carry_i(carry_i), .op_i(op_i),
        .imm_i(imm_i), .legacy_i(legacy_i),
        .acc_hi_o(acc_hi_o), .acc_lo_o(acc_lo_o),
        .aux_o(aux_o), .carry_o(carry_o), .div_err_o(div_err_o)
    );

    // Expected tuple {hi, lo, aux, carry, err}, worked out from the requirements
    function automatic logic [18:0] model(input logic [2:0] op, input int hi, input int lo,
                                          input logic af, input logic cf, input int imm,
                                          input logic leg);
        int nhi, nlo, w;
        logic naf, ncf, err;
        logic c1, c2;
        nhi = hi; nlo = lo; naf = af; ncf = cf; err = 1'b0;
        c1 = ((lo % 16) > 9) || af;
        c2 = (lo > 159) || cf;
        case (op)
            3'd0: begin
                if (c1) begin
                    if (leg) begin
                        nlo = (lo + 6) % 256; nhi = (hi + 1) % 256;
                    end else begin
                        w = (hi * 256 + lo + 6) % 65536;
                        nlo = w % 256; nhi = (w / 256 + 1) % 256;
                    end
                end
                naf = c1; ncf = c1; nlo = nlo % 16;
            end
            3'd1: begin
                if (c1) begin
                    nlo = (lo + 250) % 256; nhi = (hi + 255) % 256;
                end
                naf = c1; ncf = c1; nlo = nlo % 16;
            end
            3'd2: begin
                nlo = (lo + (c1 ? 6 : 0) + (c2 ? 96 : 0)) % 256;
                naf = c1; ncf = c2;
            end
            3'd3: begin
                nlo = (lo + 512 - (c1 ? 6 : 0) - (c2 ? 96 : 0)) % 256;
                naf = c1; ncf = c2;
            end
            3'd4: begin
                if (imm == 0) err = 1'b1;
                else begin nhi = lo / imm; nlo = lo % imm; end
            end
            3'd5: begin
                nlo = (hi * 10 + lo) % 256; nhi = 0;
            end
            default: ;
        endcase
        return {8'(nhi), 8'(nlo), naf, ncf, err};
    endfunction

    task automatic apply(input logic [2:0] op, input logic [7:0] hi, input logic [7:0] lo,
                         input logic af, input logic cf, input logic [7:0] imm, input logic leg);
        @(negedge clk);
        op_i = op; acc_hi_i = hi; acc_lo_i = lo; aux_i = af; carry_i = cf;
        imm_i = imm; legacy_i = leg;
        @(negedge clk);
    endtask

    task automatic expect_eq(input string req, input logic [18:0] exp);
        logic [18:0] got;
        got = {acc_hi_o, acc_lo_o, aux_o, carry_o, div_err_o};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got hi=%h lo=%h af=%b cf=%b err=%b, expected hi=%h lo=%h af=%b cf=%b err=%b",
                     req, got[18:11], got[10:3], got[2], got[1], got[0],
                     exp[18:11], exp[10:3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic t_reset();
        op_i = 3'd4; acc_lo_i = 8'h55; imm_i = 8'd0;
        repeat (3) @(negedge clk);
        expect_eq("R1 reset", '0);
        rst_n = 1'b1;
    endtask

    task automatic t_passthru();
        apply(3'd6, 8'h12, 8'hAB, 1'b1, 1'b0, 8'd0, 1'b0);
        expect_eq("R2 op6", {8'h12, 8'hAB, 1'b1, 1'b0, 1'b0});
        apply(3'd7, 8'hF0, 8'h0F, 1'b0, 1'b1, 8'd3, 1'b1);
        expect_eq("R2 op7", {8'hF0, 8'h0F, 1'b0, 1'b1, 1'b0});
    endtask

    task automatic t_unpacked_add();
        apply(3'd0, 8'h01, 8'h0B, 1'b0, 1'b0, 8'd10, 1'b0);
        expect_eq("R3 nibble>9", {8'h02, 8'h01, 1'b1, 1'b1, 1'b0});
        apply(3'd0, 8'h00, 8'hFA, 1'b0, 1'b0, 8'd10, 1'b0);
        expect_eq("R3 word ripple", {8'h02, 8'h00, 1'b1, 1'b1, 1'b0});
        apply(3'd0, 8'h05, 8'h37, 1'b0, 1'b1, 8'd10, 1'b0);
        expect_eq("R5 no fix clears flags", {8'h05, 8'h07, 1'b0, 1'b0, 1'b0});
    endtask

    task automatic t_legacy();
        apply(3'd0, 8'h00, 8'hFA, 1'b0, 1'b0, 8'd10, 1'b1);
        expect_eq("R4 byte only", {8'h01, 8'h00, 1'b1, 1'b1, 1'b0});
        apply(3'd0, 8'h07, 8'h02, 1'b1, 1'b0, 8'd10, 1'b1);
        expect_eq("R4 aux forced", {8'h08, 8'h08, 1'b1, 1'b1, 1'b0});
    endtask

    task automatic t_unpacked_sub();
        apply(3'd1, 8'h03, 8'h0F, 1'b0, 1'b0, 8'd10, 1'b0);
        expect_eq("R6 nibble>9", {8'h02, 8'h09, 1'b1, 1'b1, 1'b0});
        apply(3'd1, 8'h00, 8'h02, 1'b1, 1'b0, 8'd10, 1'b0);
        expect_eq("R6 aux wrap", {8'hFF, 8'h0C, 1'b1, 1'b1, 1'b0});
    endtask

    task automatic t_packed();
        apply(3'd2, 8'h44, 8'h3C, 1'b0, 1'b0, 8'd10, 1'b0);
        expect_eq("R7 low fix", {8'h44, 8'h42, 1'b1, 1'b0, 1'b0});
        apply(3'd2, 8'h44, 8'hA5, 1'b1, 1'b0, 8'd10, 1'b0);
        expect_eq("R7 both", {8'h44, 8'h0B, 1'b1, 1'b1, 1'b0});
        apply(3'd2, 8'h00, 8'h00, 1'b0, 1'b1, 8'd10, 1'b0);
        expect_eq("R7 carry in", {8'h00, 8'h60, 1'b0, 1'b1, 1'b0});
        apply(3'd3, 8'h11, 8'hFF, 1'b0, 1'b0, 8'd10, 1'b0);
        expect_eq("R8 both", {8'h11, 8'h99, 1'b1, 1'b1, 1'b0});
        apply(3'd3, 8'h11, 8'h34, 1'b1, 1'b0, 8'd10, 1'b0);
        expect_eq("R8 aux only", {8'h11, 8'h2E, 1'b1, 1'b0, 1'b0});
    endtask

    task automatic t_threshold();
        apply(3'd2, 8'h00, 8'h9B, 1'b0, 1'b0, 8'd10, 1'b0);
        expect_eq("R9 add uses input byte", {8'h00, 8'hA1, 1'b1, 1'b0, 1'b0});
        apply(3'd3, 8'h00, 8'hA0, 1'b1, 1'b0, 8'd10, 1'b0);
        expect_eq("R9 sub uses input byte", {8'h00, 8'h3A, 1'b1, 1'b1, 1'b0});
    endtask

    task automatic t_muldiv();
        apply(3'd4, 8'h00, 8'd81, 1'b1, 1'b0, 8'd10, 1'b0);
        expect_eq("R10 base ten", {8'd8, 8'd1, 1'b1, 1'b0, 1'b0});
        apply(3'd4, 8'h33, 8'd100, 1'b0, 1'b1, 8'd7, 1'b0);
        expect_eq("R10 other divisor", {8'd14, 8'd2, 1'b0, 1'b1, 1'b0});
        apply(3'd4, 8'h12, 8'h34, 1'b1, 1'b1, 8'd0, 1'b0);
        expect_eq("R11 zero divisor", {8'h12, 8'h34, 1'b1, 1'b1, 1'b1});
        apply(3'd5, 8'd7, 8'd3, 1'b0, 1'b1, 8'd0, 1'b0);
        expect_eq("R12 digits", {8'h00, 8'd73, 1'b0, 1'b1, 1'b0});
        apply(3'd5, 8'd25, 8'd16, 1'b1, 1'b0, 8'd3, 1'b0);
        expect_eq("R12 wrap", {8'h00, 8'd10, 1'b1, 1'b0, 1'b0});
    endtask

    task automatic t_sweep();
        for (int op = 0; op < 8; op++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] hi, imm;
                logic af, cf, leg;
                hi  = 8'(v) ^ 8'h5A;
                imm = 8'(v >> 1);
                af  = v[1]; cf = v[3]; leg = v[5];
                apply(3'(op), hi, 8'(v), af, cf, imm, leg);
                expect_eq("R2/R3/R6/R7/R8/R10/R12 sweep",
                          model(3'(op), int'(hi), v, af, cf, int'(imm), leg));
            end
        end
    endtask

    initial begin
        t_reset();
        t_passthru();
        t_unpacked_add();
        t_legacy();
        t_unpacked_sub();
        t_packed();
        t_threshold();
        t_muldiv();
        t_sweep();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running, expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule